// File: doc/BRIEF.md
# Scalar Register Write-After-Read Hazard Monitor

This block watches an in-order stream of decoded instructions, one descriptor per clock, and flags write-after-read ordering hazards on scalar registers that need a mitigating instruction between the two accesses. Each descriptor carries an instruction class, a mask of the scalar registers it reads, a mask of those it writes (with the execution mask and the memory-index register as two extra bits), and a few qualifiers for wait and scalar-ALU instructions.

Three rules are checked. In the first, a memory-side instruction reads a scalar register and a later scalar-ALU or scalar-memory instruction writes it. In the second, a scalar-memory instruction reads a scalar register and a later vector-ALU instruction writes it. In the third, a vector-memory access and a shared-memory access are separated by a branch, in either order. Per-register pending-read vectors hold state for the first two rules. A small flag set holds state for the third. Each rule's state is cleared by its own class of mitigating instruction. The block only reports hazards. Issue, stalling and the insertion of fixes are left to the surrounding pipeline.

Top module: `hz_scalar_war_monitor`

## Requirements
- R1: A synchronous reset clears all pending-read and branch-ordering state. After reset, no hazard is reported for reads that were recorded before the reset.
- R2: An instruction of class VMEM (0), FLAT (1), GLOBAL/SCRATCH (2) or DS (3) records the scalar registers it reads, including the execution-mask bit and the index-register bit. A later SALU (5) or SMEM (4) instruction whose write mask overlaps a recorded register reports code 1 in the same cycle. A write to a register that was not recorded reports nothing.
- R3: Any valid VALU (7) or WAIT (9) instruction clears every register recorded under R2.
- R4: An SMEM (4) instruction records the scalar registers it reads. A later VALU (7) instruction whose write mask overlaps a recorded register reports code 2 in the same cycle.
- R5: The R4 records are cleared by a SALU (5) instruction with in_salu_exempt low, or by a WAIT (9) instruction with in_wait_lgkm high. SOPP (6) instructions, exempt SALU instructions and WAIT instructions without in_wait_lgkm leave the records in place.
- R6: A VMEM (0) or GLOBAL/SCRATCH (2) instruction, then a BRANCH (8), then a DS (3) instruction reports code 3 on the DS instruction. The reverse order reports code 3 on the VMEM or GLOBAL/SCRATCH instruction. Whether the memory access is a load or a store does not matter. FLAT (1) does not take part. Without a branch between the two accesses, nothing is reported.
- R7: The R6 state is cleared only by a WAIT (9) instruction with in_wait_vs_zero high. VALU, SALU and other WAIT instructions leave it in place.
- R8: hz_flag is high exactly when hz_code is nonzero. A descriptor with in_valid low, or with a class code of 10 to 15, reports nothing and does not change any state.
- R9: Reporting a hazard does not clear its state, so a repeated offending instruction reports the hazard again until a mitigating instruction arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor present this cycle |
| in_class | input | 4 | Instruction class code (see R2 to R6) |
| in_rd_sgpr | input | NUM_SGPR | Scalar registers read |
| in_rd_exec | input | 1 | Reads the execution mask |
| in_rd_m0 | input | 1 | Reads the memory-index register |
| in_wr_sgpr | input | NUM_SGPR | Scalar registers written |
| in_wr_exec | input | 1 | Writes the execution mask |
| in_wr_m0 | input | 1 | Writes the memory-index register |
| in_salu_exempt | input | 1 | SALU instruction that does not mitigate (skip-setting or version op) |
| in_wait_lgkm | input | 1 | WAIT instruction targets the scalar/shared-memory counter |
| in_wait_vs_zero | input | 1 | WAIT instruction waits for outstanding vector stores to reach zero |
| hz_flag | output | 1 | Hazard present on this cycle's instruction |
| hz_code | output | 2 | 0 none, 1 memory-then-scalar-write, 2 SMEM-then-VALU, 3 branch sandwich |

## Verification
On every cycle, the assertions check the following. At most one rule fires at a time. Nothing fires on an invalid slot or in the first cycle after reset. Each rule is silent in the cycle after its mitigating instruction. A fired per-register hazard leaves its pending bit set. Only the bench scenarios show the rest: which register, exec and index-register overlaps actually raise which code, the exact sets of instructions that clear and do not clear each rule, that FLAT stays out of the branch pattern, and that a three-step branch sequence built over many cycles is recognised in both directions.

// File: rtl/hz_pkg.sv
package hz_pkg;

   typedef enum logic [3:0] {
      CL_VMEM   = 4'd0,
      CL_FLAT   = 4'd1,
      CL_GLOBAL = 4'd2,
      CL_DS     = 4'd3,
      CL_SMEM   = 4'd4,
      CL_SALU   = 4'd5,
      CL_SOPP   = 4'd6,
      CL_VALU   = 4'd7,
      CL_BRANCH = 4'd8,
      CL_WAIT   = 4'd9
   } hz_class_e;

   typedef enum logic [1:0] {
      HZ_NONE       = 2'd0,
      HZ_MEM_SCALAR = 2'd1,
      HZ_SMEM_VALU  = 2'd2,
      HZ_LDS_BRANCH = 2'd3
   } hz_code_e;

   // one-cycle strobes derived from a descriptor
   typedef struct packed {
      logic mem_rd;     // memory-side read records (rule A)
      logic scalar_wr;  // scalar-side write probes (rule A)
      logic clr_mem;    // rule A mitigation
      logic smem_rd;    // scalar-memory read records (rule B)
      logic valu_wr;    // vector ALU write probes (rule B)
      logic clr_smem;   // rule B mitigation
      logic vm_op;      // vector-memory side of rule C
      logic ds_op;      // shared-memory side of rule C
      logic branch;     // branch step of rule C
      logic clr_sand;   // rule C mitigation
   } hz_strobe_t;

endpackage

// File: rtl/hz_class_decode.sv
module hz_class_decode
   import hz_pkg::*;
(
   input  logic       valid,
   input  logic [3:0] cls,
   input  logic       salu_exempt,
   input  logic       wait_lgkm,
   input  logic       wait_vs_zero,
   output hz_strobe_t stb
);

   logic is_vmem, is_flat, is_glob, is_ds, is_smem, is_salu, is_valu, is_br, is_wait;

   always_comb begin
      is_vmem = valid && (cls == CL_VMEM);
      is_flat = valid && (cls == CL_FLAT);
      is_glob = valid && (cls == CL_GLOBAL);
      is_ds   = valid && (cls == CL_DS);
      is_smem = valid && (cls == CL_SMEM);
      is_salu = valid && (cls == CL_SALU);
      is_valu = valid && (cls == CL_VALU);
      is_br   = valid && (cls == CL_BRANCH);
      is_wait = valid && (cls == CL_WAIT);
   end

   always_comb begin
      stb           = '0;
      stb.mem_rd    = is_vmem || is_flat || is_glob || is_ds;
      stb.scalar_wr = is_salu || is_smem;
      stb.clr_mem   = is_valu || is_wait;
      stb.smem_rd   = is_smem;
      stb.valu_wr   = is_valu;
      stb.clr_smem  = (is_salu && !salu_exempt) || (is_wait && wait_lgkm);
      stb.vm_op     = is_vmem || is_glob;
      stb.ds_op     = is_ds;
      stb.branch    = is_br;
      stb.clr_sand  = is_wait && wait_vs_zero;
   end

endmodule

// File: rtl/hz_read_track.sv
module hz_read_track #(
   parameter int unsigned WIDTH = 130
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             set_en,
   input  logic [WIDTH-1:0] set_mask,
   input  logic             clr_all,
   input  logic             probe_en,
   input  logic [WIDTH-1:0] probe_mask,
   output logic             hit
);

   logic [WIDTH-1:0] pend;

   initial begin
      assert (WIDTH >= 1) else $error("hz_read_track: WIDTH must be at least 1");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)
            pend[g] <= 1'b0;
         else if (clr_all)
            pend[g] <= 1'b0;
         else if (set_en && set_mask[g])
            pend[g] <= 1'b1;
      end
   end

   assign hit = probe_en && (|(pend & probe_mask));

   // R9: a reported overlap is still pending one cycle later unless cleared
   a_r9_hit_persists: assert property (@(posedge clk) disable iff (rst)
      (hit && !clr_all) |=> (|(pend & $past(probe_mask))));

   // R3/R5: a clear leaves nothing to hit on the next instruction
   a_r3_clear_empties: assert property (@(posedge clk) disable iff (rst)
      clr_all |=> !hit);

endmodule

// File: rtl/hz_branch_sandwich.sv
module hz_branch_sandwich (
   input  logic clk,
   input  logic rst,
   input  logic vm_op,
   input  logic ds_op,
   input  logic branch,
   input  logic clr,
   output logic hit
);

   logic vm_seen, ds_seen, vm_then_br, ds_then_br;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         vm_seen    <= 1'b0;
         ds_seen    <= 1'b0;
         vm_then_br <= 1'b0;
         ds_then_br <= 1'b0;
      end else begin
         if (vm_op) vm_seen <= 1'b1;
         if (ds_op) ds_seen <= 1'b1;
         if (branch) begin
            vm_then_br <= vm_then_br | vm_seen;
            ds_then_br <= ds_then_br | ds_seen;
         end
      end
   end

   assign hit = (ds_op && vm_then_br) || (vm_op && ds_then_br);

   // R7: the vector-store wait removes the whole pattern
   a_r7_vs_wait_clears: assert property (@(posedge clk) disable iff (rst)
      clr |=> !hit);

   // R6: a branch step never reports by itself
   a_r6_branch_silent: assert property (@(posedge clk) disable iff (rst)
      (branch && !vm_op && !ds_op) |-> !hit);

endmodule

// File: rtl/hz_scalar_war_monitor.sv
module hz_scalar_war_monitor
   import hz_pkg::*;
#(
   parameter int unsigned NUM_SGPR = 128
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [3:0]          in_class,
   input  logic [NUM_SGPR-1:0] in_rd_sgpr,
   input  logic                in_rd_exec,
   input  logic                in_rd_m0,
   input  logic [NUM_SGPR-1:0] in_wr_sgpr,
   input  logic                in_wr_exec,
   input  logic                in_wr_m0,
   input  logic                in_salu_exempt,
   input  logic                in_wait_lgkm,
   input  logic                in_wait_vs_zero,
   output logic                hz_flag,
   output logic [1:0]          hz_code
);

   localparam int unsigned TRACK_W = NUM_SGPR + 2;

   initial begin
      assert (NUM_SGPR >= 1 && NUM_SGPR <= 1024)
         else $error("hz_scalar_war_monitor: NUM_SGPR out of range");
   end

   // execution mask at bit NUM_SGPR, index register at NUM_SGPR+1
   logic [TRACK_W-1:0] rd_vec, wr_vec;
   assign rd_vec = {in_rd_m0, in_rd_exec, in_rd_sgpr};
   assign wr_vec = {in_wr_m0, in_wr_exec, in_wr_sgpr};

   hz_strobe_t stb;

   hz_class_decode u_dec (
      .valid        (in_valid),
      .cls          (in_class),
      .salu_exempt  (in_salu_exempt),
      .wait_lgkm    (in_wait_lgkm),
      .wait_vs_zero (in_wait_vs_zero),
      .stb          (stb)
   );

   logic hit_mem, hit_smem, hit_sand;

   hz_read_track #(.WIDTH(TRACK_W)) u_mem_track (
      .clk        (clk),
      .rst        (rst),
      .set_en     (stb.mem_rd),
      .set_mask   (rd_vec),
      .clr_all    (stb.clr_mem),
      .probe_en   (stb.scalar_wr),
      .probe_mask (wr_vec),
      .hit        (hit_mem)
   );

   hz_read_track #(.WIDTH(TRACK_W)) u_smem_track (
      .clk        (clk),
      .rst        (rst),
      .set_en     (stb.smem_rd),
      .set_mask   (rd_vec),
      .clr_all    (stb.clr_smem),
      .probe_en   (stb.valu_wr),
      .probe_mask (wr_vec),
      .hit        (hit_smem)
   );

   hz_branch_sandwich u_sand (
      .clk    (clk),
      .rst    (rst),
      .vm_op  (stb.vm_op),
      .ds_op  (stb.ds_op),
      .branch (stb.branch),
      .clr    (stb.clr_sand),
      .hit    (hit_sand)
   );

   hz_code_e code_c;

   always_comb begin
      if (hit_mem)       code_c = HZ_MEM_SCALAR;
      else if (hit_smem) code_c = HZ_SMEM_VALU;
      else if (hit_sand) code_c = HZ_LDS_BRANCH;
      else               code_c = HZ_NONE;
   end

   assign hz_code = code_c;
   assign hz_flag = (code_c != HZ_NONE);

   // R8: the three rules are separated by instruction class
   a_r8_one_rule: assert property (@(posedge clk) disable iff (rst)
      $onehot0({hit_mem, hit_smem, hit_sand}));

   // R8: an empty slot never reports
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> !hz_flag);

   // R1: first instruction after reset sees clean state
   a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !hz_flag);

   // R3: a vector ALU op removes the memory-then-scalar hazard
   a_r3_valu_mitigates: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_class == CL_VALU) |=> (hz_code != HZ_MEM_SCALAR));

   // R5: a non-exempt scalar ALU op removes the SMEM-then-VALU hazard
   a_r5_salu_mitigates: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_class == CL_SALU && !in_salu_exempt) |=> (hz_code != HZ_SMEM_VALU));

endmodule

// File: tb/hz_scalar_war_monitor_test.sv
module hz_scalar_war_monitor_test;

   localparam int NS = 128;

   logic clk = 1'b0;
   logic rst;
   logic in_valid;
   logic [3:0] in_class;
   logic [NS-1:0] in_rd_sgpr, in_wr_sgpr;
   logic in_rd_exec, in_rd_m0, in_wr_exec, in_wr_m0;
   logic in_salu_exempt, in_wait_lgkm, in_wait_vs_zero;
   logic hz_flag;
   logic [1:0] hz_code;

   always #2 clk = ~clk;   // 250 MHz

   hz_scalar_war_monitor #(.NUM_SGPR(NS)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
      .in_rd_sgpr(in_rd_sgpr), .in_rd_exec(in_rd_exec), .in_rd_m0(in_rd_m0),
      .in_wr_sgpr(in_wr_sgpr), .in_wr_exec(in_wr_exec), .in_wr_m0(in_wr_m0),
      .in_salu_exempt(in_salu_exempt), .in_wait_lgkm(in_wait_lgkm),
      .in_wait_vs_zero(in_wait_vs_zero), .hz_flag(hz_flag), .hz_code(hz_code)
   );

   // class codes from the requirements
   localparam logic [3:0] K_VM = 0, K_FL = 1, K_GL = 2, K_DS = 3, K_SM = 4,
                          K_SA = 5, K_SO = 6, K_VA = 7, K_BR = 8, K_WT = 9, K_RSV = 12;
   // register index: 0..127 sgpr, 128 exec, 129 index register, 255 none
   localparam logic [7:0] N = 8'd255, EX = 8'd128, MZ = 8'd129;

   // {req[3:0], valid, cls[3:0], rd[7:0], wr[7:0], exempt, lgkm, vs0, exp[1:0]}
   function automatic logic [29:0] mk(input logic [3:0] rq, input logic v, input logic [3:0] c,
                                      input logic [7:0] r, input logic [7:0] w,
                                      input logic ex, input logic lg, input logic vs,
                                      input logic [1:0] e);
      return {rq, v, c, r, w, ex, lg, vs, e};
   endfunction

   localparam int NV = 57;
   localparam logic [29:0] TBL [NV] = '{
      mk(2, 1, K_VM, 5,  N,  0,0,0, 0),  // R2 record s5
      mk(2, 1, K_SA, N,  6,  0,0,0, 0),  // R2 other register
      mk(2, 1, K_SA, N,  5,  0,0,0, 1),  // R2 overlap
      mk(9, 1, K_SM, N,  5,  0,0,0, 1),  // R9 persists, SMEM write
      mk(3, 1, K_VA, N,  N,  0,0,0, 0),  // R3 VALU clears
      mk(3, 1, K_SA, N,  5,  0,0,0, 0),  // R3
      mk(2, 1, K_DS, EX, N,  0,0,0, 0),  // R2 exec read
      mk(3, 1, K_WT, N,  N,  0,0,0, 0),  // R3 wait clears
      mk(3, 1, K_SA, N,  EX, 0,0,0, 0),  // R3
      mk(2, 1, K_FL, MZ, N,  0,0,0, 0),  // R2 index reg via FLAT
      mk(2, 1, K_SM, N,  MZ, 0,0,0, 1),  // R2
      mk(3, 1, K_WT, N,  N,  0,0,0, 0),  // R3
      mk(4, 1, K_SM, 10, N,  0,0,0, 0),  // R4 record s10
      mk(5, 1, K_SO, N,  N,  0,0,0, 0),  // R5 SOPP keeps
      mk(5, 1, K_SA, N,  N,  1,0,0, 0),  // R5 exempt keeps
      mk(5, 1, K_WT, N,  N,  0,0,0, 0),  // R5 non-lgkm wait keeps
      mk(4, 1, K_VA, N,  10, 0,0,0, 2),  // R4 overlap
      mk(4, 1, K_VA, N,  11, 0,0,0, 0),  // R4 other register
      mk(5, 1, K_SA, N,  N,  0,0,0, 0),  // R5 SALU clears
      mk(5, 1, K_VA, N,  10, 0,0,0, 0),  // R5
      mk(4, 1, K_SM, 127,N,  0,0,0, 0),  // R4 top register
      mk(5, 1, K_WT, N,  N,  0,1,0, 0),  // R5 lgkm wait clears
      mk(5, 1, K_VA, N,  127,0,0,0, 0),  // R5
      mk(4, 1, K_SM, EX, N,  0,0,0, 0),  // R4 exec
      mk(4, 1, K_VA, N,  EX, 0,0,0, 2),  // R4
      mk(5, 1, K_SA, N,  N,  0,0,0, 0),  // R5
      mk(6, 1, K_GL, N,  N,  0,0,0, 0),  // R6 forward
      mk(6, 1, K_BR, N,  N,  0,0,0, 0),  // R6
      mk(6, 1, K_DS, N,  N,  0,0,0, 3),  // R6
      mk(7, 1, K_WT, N,  N,  0,0,1, 0),  // R7 clear
      mk(6, 1, K_DS, N,  N,  0,0,0, 0),  // R6 reverse
      mk(6, 1, K_BR, N,  N,  0,0,0, 0),  // R6
      mk(7, 1, K_VA, N,  N,  0,0,0, 0),  // R7 VALU keeps
      mk(7, 1, K_SA, N,  N,  0,0,0, 0),  // R7 SALU keeps
      mk(7, 1, K_WT, N,  N,  0,1,0, 0),  // R7 lgkm wait keeps
      mk(6, 1, K_VM, N,  N,  0,0,0, 3),  // R6 reverse fires
      mk(7, 1, K_WT, N,  N,  0,0,1, 0),  // R7
      mk(6, 1, K_FL, N,  N,  0,0,0, 0),  // R6 FLAT excluded
      mk(6, 1, K_BR, N,  N,  0,0,0, 0),  // R6
      mk(6, 1, K_DS, N,  N,  0,0,0, 0),  // R6
      mk(6, 1, K_VM, N,  N,  0,0,0, 0),  // R6 no branch between
      mk(6, 1, K_DS, N,  N,  0,0,0, 0),  // R6
      mk(6, 1, K_BR, N,  N,  0,0,0, 0),  // R6
      mk(6, 1, K_VM, N,  N,  0,0,0, 3),  // R6
      mk(9, 1, K_DS, N,  N,  0,0,0, 3),  // R9 both directions stay armed
      mk(7, 1, K_WT, N,  N,  0,0,1, 0),  // R7
      mk(8, 0, K_VM, 20, N,  0,0,0, 0),  // R8 invalid read not recorded
      mk(8, 1, K_SA, N,  20, 0,0,0, 0),  // R8
      mk(8, 1, K_RSV,20, N,  0,0,0, 0),  // R8 reserved class
      mk(8, 1, K_SA, N,  20, 0,0,0, 0),  // R8
      mk(2, 1, K_VM, 21, N,  0,0,0, 0),  // R2
      mk(8, 0, K_SA, N,  21, 0,0,0, 0),  // R8 invalid write silent
      mk(8, 1, K_SA, N,  21, 0,0,0, 1),  // R8 state unchanged
      mk(8, 0, K_VA, N,  N,  0,0,0, 0),  // R8 invalid VALU no clear
      mk(9, 1, K_SA, N,  21, 0,0,0, 1),  // R9
      mk(8, 1, K_RSV,N,  N,  0,0,0, 0),  // R8 reserved no clear
      mk(9, 1, K_SA, N,  21, 0,0,0, 1)   // R9
   };

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   task automatic drive(input logic v, input logic [3:0] c, input logic [7:0] r,
                        input logic [7:0] w, input logic ex, input logic lg, input logic vs);
      in_valid   = v;
      in_class   = c;
      in_rd_sgpr = '0;
      in_wr_sgpr = '0;
      if (r < 8'd128) in_rd_sgpr[r[6:0]] = 1'b1;
      if (w < 8'd128) in_wr_sgpr[w[6:0]] = 1'b1;
      in_rd_exec = (r == EX);
      in_rd_m0   = (r == MZ);
      in_wr_exec = (w == EX);
      in_wr_m0   = (w == MZ);
      in_salu_exempt  = ex;
      in_wait_lgkm    = lg;
      in_wait_vs_zero = vs;
   endtask

   task automatic check(input logic [1:0] exp, input string tag);
      logic exp_flag;
      exp_flag = (exp != 2'd0);
      n_checks++;
      if (hz_code !== exp || hz_flag !== exp_flag) begin
         n_fail++;
         $display("FAIL %s: flag/code %b/%0d expected %b/%0d", tag, hz_flag, hz_code, exp_flag, exp);
      end
   endtask

   // one instruction slot: drive after the falling edge, sample before the rising edge
   task automatic slot(input logic v, input logic [3:0] c, input logic [7:0] r,
                       input logic [7:0] w, input logic ex, input logic lg, input logic vs,
                       input logic [1:0] exp, input string tag);
      @(negedge clk);
      drive(v, c, r, w, ex, lg, vs);
      #1;
      check(exp, tag);
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst = 1'b1;
      drive(0, K_SO, N, N, 0, 0, 0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      rst = 1'b1;
      drive(0, K_SO, N, N, 0, 0, 0);
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      slot(0, K_SO, N, N, 0, 0, 0, 2'd0, "R1 idle after reset");
      slot(1, K_SA, N, 0, 0, 0, 0, 2'd0, "R1 clean tracker");

      for (int i = 0; i < NV; i++) begin
         logic [29:0] e;
         string tag;
         e = TBL[i];
         tag = $sformatf("R%0d row %0d", e[29:26], i);
         slot(e[25], e[24:21], e[20:13], e[12:5], e[4], e[3], e[2], e[1:0], tag);
      end

      // R1: reset in mid-stream drops each kind of state
      slot(1, K_VM, 30, N, 0, 0, 0, 2'd0, "R1 setup memory read");
      pulse_reset();
      slot(1, K_SA, N, 30, 0, 0, 0, 2'd0, "R1 memory read dropped");
      slot(1, K_SM, 31, N, 0, 0, 0, 2'd0, "R1 setup smem read");
      pulse_reset();
      slot(1, K_VA, N, 31, 0, 0, 0, 2'd0, "R1 smem read dropped");
      slot(1, K_GL, N, N, 0, 0, 0, 2'd0, "R1 setup global");
      slot(1, K_BR, N, N, 0, 0, 0, 2'd0, "R1 setup branch");
      pulse_reset();
      slot(1, K_DS, N, N, 0, 0, 0, 2'd0, "R1 sandwich dropped");

      // R2: multi-bit masks, overlap on a single shared register
      @(negedge clk);
      drive(1, K_DS, N, N, 0, 0, 0);
      in_rd_sgpr[0] = 1'b1; in_rd_sgpr[64] = 1'b1; in_rd_m0 = 1'b1;
      #1; check(2'd0, "R2 multi-read record");
      @(negedge clk);
      drive(1, K_SA, N, N, 0, 0, 0);
      in_wr_sgpr[1] = 1'b1; in_wr_sgpr[63] = 1'b1; in_wr_sgpr[64] = 1'b1;
      #1; check(2'd1, "R2 multi-write overlap");

      finish_run();
   end

endmodule